// File: doc/BRIEF.md
# Phase-Accumulator Oscillator with Rotation-Pipeline Quadrature Mixer

This block converts a real sample stream to a complex pair by mixing it with a locally generated oscillator. A phase register advances by a signed frequency step on every clock and wraps modulo 2^PHASE_W. The step is computed as (wanted oscillator frequency / clock rate) x 2^PHASE_W. Its sign chooses the rotation direction, so the oscillator frequency can be positive or negative and can reach half the clock rate. A one-cycle sync pulse loads the phase register with a programmable offset. That offset is usually zero, and the pulse lets several channels start from a known, coherent phase.

The cosine and sine of the phase are produced by an iterative vector-rotation pipeline rather than a lookup table. The two upper phase bits pick the quadrant. The remaining bits are rotated through OUT_W shift-and-add stages, and the signs and axes are then swapped back to match the quadrant. The starting vector is scaled down by the rotation gain, so the oscillator amplitude settles just under full scale. The input sample travels through a delay line of the same depth as the rotation pipeline. Each sample therefore meets the phase value that was current when it entered. It is then placed in the top bits of an OUT_W-bit word and multiplied by cosine to give I and by sine to give Q.

Top module: `nco_cordic_mixer`

## Requirements
- R1: While rst_n is low at a clock edge, and after that edge, out_valid_o, i_o and q_o are all zero.
- R2: If sync_i is low at an edge, the phase advances by freq_step_i modulo 2^PHASE_W. Steps at or near half a revolution (0x8000_0000, 0x7FFF_FFF0 with PHASE_W=32) wrap correctly.
- R3: A negative freq_step_i (two's complement) rotates the oscillator the other way, so the sign of Q is reversed compared with the positive step of the same size.
- R4: If sync_i is high at an edge, the phase becomes phase_ofs_i. The next sample accepted uses exactly that phase, and the samples after it use the offset plus k steps.
- R5: The oscillator amplitude is A = 2^(OUT_W-1)-4 to within ±6 LSB per component and ±8 in vector magnitude. No component ever goes beyond ±(2^(OUT_W-1)-1).
- R6: All four quadrants are correct. Phase bits [PHASE_W-1:PHASE_W-2] = 0,1,2,3 place the vector at angles 0°, 90°, 180° and 270° plus the residual angle.
- R7: i_o = s·cos(θ) and q_o = s·sin(θ), taken as signed products 2·OUT_W bits wide. Here s is sample_i shifted left by OUT_W-DATA_W with zero low bits, and θ = 2π·phase/2^PHASE_W.
- R8: A sample taken at edge n appears on the outputs after edge n+OUT_W+2. out_valid_o then equals the in_valid_i of edge n, and I and Q are computed whether or not the sample is valid.
- R9: Each output pairs a sample with the phase held in the phase register at the edge that accepted that sample, and not with the phase of a neighbouring edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_i | input | 1 | Loads the phase register with the offset |
| freq_step_i | input | PHASE_W | Signed phase increment per clock |
| phase_ofs_i | input | PHASE_W | Phase loaded on sync |
| in_valid_i | input | 1 | Marks sample_i as a valid sample |
| sample_i | input | DATA_W | Real two's-complement input sample |
| out_valid_o | output | 1 | Delayed in_valid_i aligned with I and Q |
| i_o | output | 2*OUT_W | In-phase product |
| q_o | output | 2*OUT_W | Quadrature product |

## Verification
The bench builds the block with PHASE_W=32, OUT_W=16, DATA_W=12 and GUARD=3. That gives 16 rotation stages and an 18-edge sample-to-output delay. Because DATA_W is smaller than OUT_W, the 4-bit MSB justification becomes visible, and the extreme codes 2047 and -2048 test the multiplier ends. With a 32-bit phase, the bench can use steps that wrap at exactly half a revolution, and offsets that fall on every quadrant boundary and between them.

// File: rtl/nco_pkg.sv
// Shared types and elaboration-time helpers for the oscillator/mixer.
// Assumes real arithmetic is only used to derive constants.
package nco_pkg;

    localparam real NCO_PI = 3.14159265358979323846;

    // Quadrant selected by the two upper phase bits
    typedef enum logic [1:0] {
        QUAD_0 = 2'd0,
        QUAD_1 = 2'd1,
        QUAD_2 = 2'd2,
        QUAD_3 = 2'd3
    } quad_e;

    // Total magnitude growth of a rotation pipeline with n stages
    function automatic real cordic_gain(input int n);
        real g;
        g = 1.0;
        for (int k = 0; k < n; k++) begin
            g = g * $sqrt(1.0 + 2.0 ** (-2 * k));
        end
        return g;
    endfunction

endpackage

// File: rtl/nco_phase_acc.sv
// Phase register: adds a signed step each clock, modulo 2^PHASE_W.
// A sync pulse loads the offset instead. Assumes the step and offset are
// stable around the edge where they are used.
module nco_phase_acc #(
    parameter int PHASE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_i,
    input  logic [PHASE_W-1:0] step_i,
    input  logic [PHASE_W-1:0] ofs_i,
    output logic [PHASE_W-1:0] phase_o
);

    // Accumulate the step, or restart from the offset on sync
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_o <= '0;
        end else if (sync_i) begin
            phase_o <= ofs_i;
        end else begin
            phase_o <= phase_o + step_i;
        end
    end

endmodule

// File: rtl/nco_cordic.sv
// Pipelined shift-and-add rotation giving cos/sin of an unsigned phase.
// The upper two phase bits choose the quadrant and the rest are rotated.
// The start vector is pre-divided by the pipeline gain, so the output
// amplitude is 2^(OUT_W-1)-4. Latency: STAGES+2 registered edges.
module nco_cordic #(
    parameter int PHASE_W = 32,
    parameter int OUT_W   = 16,
    parameter int STAGES  = 16,
    parameter int GUARD   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PHASE_W-1:0]       phase_i,
    output logic signed [OUT_W-1:0]  cos_o,
    output logic signed [OUT_W-1:0]  sin_o
);
    import nco_pkg::*;

    localparam int     IW   = OUT_W + GUARD + 2;
    localparam int     ZW   = PHASE_W;
    localparam int     AMP  = 2 ** (OUT_W - 1) - 4;
    localparam int     LIM  = 2 ** (OUT_W - 1) - 1;
    localparam real    GAIN = cordic_gain(STAGES);
    localparam longint X0   = longint'(real'(AMP) * (2.0 ** GUARD) / GAIN);

    logic signed [IW-1:0] x_q    [STAGES+1];
    logic signed [IW-1:0] y_q    [STAGES+1];
    logic signed [ZW-1:0] z_q    [STAGES+1];
    quad_e                quad_q [STAGES+1];
    logic signed [ZW-1:0] ang_w  [STAGES];

    // One arctangent constant per stage, in phase units
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_atan
            localparam real    ANG_R = $atan(2.0 ** (-g)) * (2.0 ** PHASE_W) / (2.0 * NCO_PI);
            localparam longint ANG_L = longint'(ANG_R);
            assign ang_w[g] = ZW'(ANG_L);
        end
    endgenerate

    // Clamp to the symmetric output range
    function automatic logic signed [OUT_W-1:0] clamp(input logic signed [IW-1:0] v);
        if (v > IW'(LIM))       return OUT_W'(LIM);
        else if (v < -IW'(LIM)) return -OUT_W'(LIM);
        else                    return v[OUT_W-1:0];
    endfunction

    // Quadrant fold at the input, then one rotation per stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k <= STAGES; k++) begin
                x_q[k]    <= '0;
                y_q[k]    <= '0;
                z_q[k]    <= '0;
                quad_q[k] <= QUAD_0;
            end
        end else begin
            x_q[0]    <= IW'(X0);
            y_q[0]    <= '0;
            z_q[0]    <= {2'b00, phase_i[PHASE_W-3:0]};
            quad_q[0] <= quad_e'(phase_i[PHASE_W-1 -: 2]);
            for (int k = 0; k < STAGES; k++) begin
                if (z_q[k][ZW-1]) begin
                    x_q[k+1] <= x_q[k] + (y_q[k] >>> k);
                    y_q[k+1] <= y_q[k] - (x_q[k] >>> k);
                    z_q[k+1] <= z_q[k] + ang_w[k];
                end else begin
                    x_q[k+1] <= x_q[k] - (y_q[k] >>> k);
                    y_q[k+1] <= y_q[k] + (x_q[k] >>> k);
                    z_q[k+1] <= z_q[k] - ang_w[k];
                end
                quad_q[k+1] <= quad_q[k];
            end
        end
    end

    logic signed [OUT_W-1:0] c_w, s_w;
    assign c_w = clamp(x_q[STAGES] >>> GUARD);
    assign s_w = clamp(y_q[STAGES] >>> GUARD);

    // Unfold the quadrant by swapping and negating the axes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cos_o <= '0;
            sin_o <= '0;
        end else begin
            unique case (quad_q[STAGES])
                QUAD_0: begin cos_o <= c_w;  sin_o <= s_w;  end
                QUAD_1: begin cos_o <= -s_w; sin_o <= c_w;  end
                QUAD_2: begin cos_o <= -c_w; sin_o <= -s_w; end
                QUAD_3: begin cos_o <= s_w;  sin_o <= -c_w; end
            endcase
        end
    end

endmodule

// File: rtl/nco_mixer.sv
// Delays the input sample and its valid flag by DELAY edges, so each sample
// meets the oscillator value of its own phase. The sample is placed in the
// top bits of an OUT_W word and multiplied by cos and sin.
// Assumes DATA_W <= OUT_W and DELAY >= 2.
module nco_mixer #(
    parameter int DATA_W = 12,
    parameter int OUT_W  = 16,
    parameter int DELAY  = 18
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid_i,
    input  logic signed [DATA_W-1:0]  sample_i,
    input  logic signed [OUT_W-1:0]   cos_i,
    input  logic signed [OUT_W-1:0]   sin_i,
    output logic                      out_valid_o,
    output logic signed [2*OUT_W-1:0] i_o,
    output logic signed [2*OUT_W-1:0] q_o
);

    localparam int SHIFT = OUT_W - DATA_W;
    localparam int PW    = 2 * OUT_W;

    logic signed [OUT_W-1:0] just_w;
    logic signed [OUT_W-1:0] d_q [DELAY];
    logic [DELAY-1:0]        v_q;

    assign just_w = OUT_W'(sample_i) <<< SHIFT;

    // Delay line matching the rotation pipeline
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DELAY; k++) d_q[k] <= '0;
            v_q <= '0;
        end else begin
            d_q[0] <= just_w;
            for (int k = 1; k < DELAY; k++) d_q[k] <= d_q[k-1];
            v_q <= {v_q[DELAY-2:0], in_valid_i};
        end
    end

    // Signed products registered at the output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i_o         <= '0;
            q_o         <= '0;
            out_valid_o <= 1'b0;
        end else begin
            i_o         <= PW'(d_q[DELAY-1]) * PW'(cos_i);
            q_o         <= PW'(d_q[DELAY-1]) * PW'(sin_i);
            out_valid_o <= v_q[DELAY-1];
        end
    end

endmodule

// File: rtl/nco_cordic_mixer.sv
// Top: phase register, rotation pipeline and quadrature mixer.
// Assumes DATA_W <= OUT_W. A sample is presented OUT_W+2 edges after
// the edge that accepted it.
module nco_cordic_mixer #(
    parameter int PHASE_W = 32,
    parameter int OUT_W   = 16,
    parameter int DATA_W  = 12,
    parameter int GUARD   = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sync_i,
    input  logic [PHASE_W-1:0]        freq_step_i,
    input  logic [PHASE_W-1:0]        phase_ofs_i,
    input  logic                      in_valid_i,
    input  logic signed [DATA_W-1:0]  sample_i,
    output logic                      out_valid_o,
    output logic signed [2*OUT_W-1:0] i_o,
    output logic signed [2*OUT_W-1:0] q_o
);

    localparam int STAGES = OUT_W;
    localparam int DLY    = STAGES + 2;

    logic [PHASE_W-1:0]      phase_q;
    logic signed [OUT_W-1:0] cos_w, sin_w;

    nco_phase_acc #(.PHASE_W(PHASE_W)) acc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (sync_i),
        .step_i (freq_step_i),
        .ofs_i  (phase_ofs_i),
        .phase_o(phase_q)
    );

    nco_cordic #(
        .PHASE_W(PHASE_W), .OUT_W(OUT_W), .STAGES(STAGES), .GUARD(GUARD)
    ) rot_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .phase_i(phase_q),
        .cos_o  (cos_w),
        .sin_o  (sin_w)
    );

    nco_mixer #(.DATA_W(DATA_W), .OUT_W(OUT_W), .DELAY(DLY)) mix_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid_i (in_valid_i),
        .sample_i   (sample_i),
        .cos_i      (cos_w),
        .sin_i      (sin_w),
        .out_valid_o(out_valid_o),
        .i_o        (i_o),
        .q_o        (q_o)
    );

endmodule

// File: rtl/nco_cordic_mixer_chk.sv
// Property checker bound to nco_cordic_mixer. It keeps its own shift
// registers for valid and zero-sample flags, and a fill counter.
module nco_cordic_mixer_chk #(
    parameter int PHASE_W = 32,
    parameter int OUT_W   = 16,
    parameter int DATA_W  = 12,
    parameter int DLY     = 18
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      sync_i,
    input logic [PHASE_W-1:0]        phase_ofs_i,
    input logic                      in_valid_i,
    input logic signed [DATA_W-1:0]  sample_i,
    input logic                      out_valid_o,
    input logic signed [2*OUT_W-1:0] i_o,
    input logic signed [2*OUT_W-1:0] q_o,
    input logic [PHASE_W-1:0]        phase,
    input logic signed [OUT_W-1:0]   osc_cos,
    input logic signed [OUT_W-1:0]   osc_sin
);

    localparam longint AMP = 2 ** (OUT_W - 1) - 4;
    localparam longint LO  = (AMP - 8) * (AMP - 8);
    localparam longint HI  = (AMP + 8) * (AMP + 8);

    logic [DLY:0] vl_q, zf_q;
    int           fill_q;
    longint       mag_w;

    // Expected valid and zero-sample history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vl_q   <= '0;
            zf_q   <= '0;
            fill_q <= 0;
        end else begin
            vl_q   <= {vl_q[DLY-1:0], in_valid_i};
            zf_q   <= {zf_q[DLY-1:0], sample_i == '0};
            fill_q <= (fill_q > DLY) ? fill_q : fill_q + 1;
        end
    end

    assign mag_w = longint'(osc_cos) * longint'(osc_cos) + longint'(osc_sin) * longint'(osc_sin);

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o == vl_q[DLY]);                                     // R8
    AST_SYNC_LOADS_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> phase == $past(phase_ofs_i));                       // R4
    AST_OSC_MAGNITUDE: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_q > DLY) |-> (mag_w >= LO && mag_w <= HI));              // R5
    AST_ZERO_SAMPLE_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        zf_q[DLY] |-> (i_o == '0 && q_o == '0));                       // R7

endmodule

bind nco_cordic_mixer nco_cordic_mixer_chk #(
    .PHASE_W(PHASE_W), .OUT_W(OUT_W), .DATA_W(DATA_W), .DLY(DLY)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_i     (sync_i),
    .phase_ofs_i(phase_ofs_i),
    .in_valid_i (in_valid_i),
    .sample_i   (sample_i),
    .out_valid_o(out_valid_o),
    .i_o        (i_o),
    .q_o        (q_o),
    .phase      (phase_q),
    .osc_cos    (cos_w),
    .osc_sin    (sin_w)
);

// File: tb/nco_cordic_mixer_tb_top.sv
// Directed bench: each task drives one scenario. A model of the phase
// register records every accepted sample, and the monitor compares each
// output OUT_W+2 edges later against values computed from the requirements.
module nco_cordic_mixer_tb_top;

    localparam int PHASE_W = 32;
    localparam int OUT_W   = 16;
    localparam int DATA_W  = 12;
    localparam int DLY     = OUT_W + 2;
    localparam int RING    = 64;
    localparam real AMP    = 32764.0;
    localparam real TWO_PI = 6.28318530717958647692;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      sync_i = 1'b0;
    logic [PHASE_W-1:0]        freq_step_i = '0;
    logic [PHASE_W-1:0]        phase_ofs_i = '0;
    logic                      in_valid_i = 1'b0;
    logic signed [DATA_W-1:0]  sample_i = '0;
    logic                      out_valid_o;
    logic signed [2*OUT_W-1:0] i_o, q_o;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    bit    mon_en = 1'b0;
    int    edge_cnt = 0;
    string cur_tag = "R1";

    logic [PHASE_W-1:0] ph_m = '0;
    bit                 rec_v [RING];
    int                 rec_d [RING];
    logic [PHASE_W-1:0] rec_p [RING];
    string              rec_t [RING];

    always #4 clk = ~clk;

    nco_cordic_mixer #(
        .PHASE_W(PHASE_W), .OUT_W(OUT_W), .DATA_W(DATA_W), .GUARD(3)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_i),
        .freq_step_i(freq_step_i), .phase_ofs_i(phase_ofs_i),
        .in_valid_i(in_valid_i), .sample_i(sample_i),
        .out_valid_o(out_valid_o), .i_o(i_o), .q_o(q_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Phase model and sample record at each edge (inputs change at negedge)
    always @(posedge clk) begin
        int idx;
        idx = edge_cnt % RING;
        rec_v[idx] = rst_n && in_valid_i;
        rec_d[idx] = int'(sample_i);
        rec_p[idx] = ph_m;
        rec_t[idx] = cur_tag;
        if (!rst_n)      ph_m = '0;
        else if (sync_i) ph_m = phase_ofs_i;
        else             ph_m = ph_m + freq_step_i;
        edge_cnt++;
    end

    // Output monitor: result of edge n appears after edge n+DLY
    always @(negedge clk) begin
        int     idx;
        longint dj, act_i, act_q, tol, lim;
        real    th, ei, eq;
        if (mon_en && edge_cnt > DLY) begin
            idx = (edge_cnt - 1 - DLY) % RING;
            check(out_valid_o == rec_v[idx], "R8", "out_valid alignment",
                  longint'(out_valid_o), longint'(rec_v[idx]));
            dj    = longint'(rec_d[idx]) * (2 ** (OUT_W - DATA_W));
            th    = TWO_PI * real'(longint'(rec_p[idx])) / 4294967296.0;
            ei    = real'(dj) * AMP * $cos(th);
            eq    = real'(dj) * AMP * $sin(th);
            tol   = (dj < 0 ? -dj : dj) * 6 + 2;
            lim   = (dj < 0 ? -dj : dj) * 32767;
            act_i = longint'(i_o);
            act_q = longint'(q_o);
            if (rec_v[idx]) begin
                check(real'(act_i) - ei <= real'(tol) && ei - real'(act_i) <= real'(tol),
                      rec_t[idx], "I product", act_i, longint'(ei));
                check(real'(act_q) - eq <= real'(tol) && eq - real'(act_q) <= real'(tol),
                      rec_t[idx], "Q product", act_q, longint'(eq));
                check(act_i <= lim && -act_i <= lim && act_q <= lim && -act_q <= lim,
                      "R5", "full-scale bound", act_i, lim);
            end
        end
    end

    task automatic drain();
        @(negedge clk);
        in_valid_i = 1'b0;
        sync_i     = 1'b0;
        repeat (DLY + 2) @(negedge clk);
    endtask

    task automatic start(input logic [PHASE_W-1:0] step, input logic [PHASE_W-1:0] ofs);
        @(negedge clk);
        freq_step_i = step;
        phase_ofs_i = ofs;
        sync_i      = 1'b1;
        in_valid_i  = 1'b0;
        @(negedge clk);
        sync_i = 1'b0;
    endtask

    task automatic feed(input int n, input int val);
        for (int k = 0; k < n; k++) begin
            in_valid_i = 1'b1;
            sample_i   = DATA_W'(val);
            @(negedge clk);
        end
        in_valid_i = 1'b0;
    endtask

    // R1: reset holds every output at zero
    task automatic t_reset();
        cur_tag = "R1";
        rst_n = 1'b0;
        in_valid_i = 1'b1;
        sample_i = 12'sd1000;
        repeat (4) begin
            @(negedge clk);
            check(out_valid_o == 1'b0 && i_o == '0 && q_o == '0, "R1",
                  "outputs in reset", longint'(i_o) + longint'(out_valid_o), 0);
        end
        in_valid_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid_o == 1'b0, "R1", "valid after reset", longint'(out_valid_o), 0);
        mon_en = 1'b1;
    endtask

    // R6: offsets on and between every quadrant boundary, zero step
    task automatic t_quadrants();
        logic [PHASE_W-1:0] ofs [8];
        cur_tag = "R6";
        ofs = '{32'h0000_0000, 32'h2000_0000, 32'h4000_0000, 32'h6000_0000,
                32'h8000_0000, 32'hA000_0000, 32'hC000_0000, 32'hE555_5555};
        for (int k = 0; k < 8; k++) begin
            start('0, ofs[k]);
            feed(3, 1500);
        end
        drain();
    endtask

    // R4: sync mid-stream restarts from the offset
    task automatic t_sync();
        cur_tag = "R4";
        start(32'h0100_0000, 32'h1234_5678);
        feed(10, -900);
        sync_i      = 1'b1;
        phase_ofs_i = 32'h9ABC_DEF0;
        in_valid_i  = 1'b1;
        sample_i    = 12'sd700;
        @(negedge clk);
        sync_i = 1'b0;
        feed(10, 700);
        drain();
    endtask

    // R2: positive step, and steps at half a revolution that wrap
    task automatic t_step_pos();
        cur_tag = "R2";
        start(32'd107374182, '0);
        feed(50, 2000);
        start(32'h8000_0000, 32'h0100_0000);
        feed(8, 1800);
        start(32'h7FFF_FFF0, '0);
        feed(8, -1800);
        drain();
    endtask

    // R3: negative step reverses rotation
    task automatic t_step_neg();
        cur_tag = "R3";
        start(-32'd107374182, '0);
        feed(50, 2000);
        drain();
    endtask

    // R9: ramp input with odd step so a one-edge skew is visible
    task automatic t_align();
        cur_tag = "R9";
        start(32'h0A3D_70A3, 32'h0765_4321);
        for (int k = 0; k < 40; k++) begin
            in_valid_i = 1'b1;
            sample_i   = DATA_W'(-2000 + 97 * k);
            @(negedge clk);
        end
        drain();
    endtask

    // R8: gaps in the valid stream propagate with the data
    task automatic t_gaps();
        cur_tag = "R8";
        start(32'h0321_0000, '0);
        for (int k = 0; k < 30; k++) begin
            in_valid_i = (k % 3) != 1;
            sample_i   = DATA_W'(300 + 11 * k);
            @(negedge clk);
        end
        drain();
    endtask

    // R7/R5: extreme codes show the MSB justification and bounds
    task automatic t_extremes();
        cur_tag = "R7";
        start(32'h0500_0000, 32'h1000_0000);
        feed(8, 2047);
        feed(8, -2048);
        feed(4, -1);
        feed(4, 1);
        feed(4, 0);
        drain();
    endtask

    initial begin
        t_reset();
        t_quadrants();
        t_sync();
        t_step_pos();
        t_step_neg();
        t_align();
        t_gaps();
        t_extremes();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL %s watchdog: actual %0d expected %0d", cur_tag, 200000, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule